// File: doc/BRIEF.md
# Micro-op dispatch gate with stall accounting

This block sits between a queue of decoded instructions and the out-of-order backend. Each cycle it looks at up to `LANES` queued instructions, oldest in lane 0. It accepts the longest run of them, starting at lane 0, that fits every backend limit at once. The limits are the dispatch width counted in micro-ops, free reorder-buffer entries, physical registers left for renaming, scheduler queue room, and load-queue and store-queue room. A static rule also applies: an instruction flagged as needing its own group must lead it and ends it. The accepted lanes are strobed on `in_ready`, and the queue drops them on the next edge.

When the oldest refused instruction was stopped by something other than the group being full, the cycle is a stall. The block gives it exactly one cause code by fixed priority. It keeps a saturating counter per cause and a histogram of the number of micro-ops dispatched per cycle. A synchronous clear input zeroes all statistics.

Top module: `dispatch_gate`

## Requirements
- R1: `in_ready` is always a contiguous run of valid lanes starting at lane 0. An invalid or refused lane blocks every younger lane in that cycle.
- R2: An instruction joins only if the micro-ops already in the group plus its own micro-ops do not exceed the effective width, so `disp_uops` never exceeds that width.
- R3: A `cfg_width` of 0 gives an effective width of `DEF_WIDTH` (2 at default). A value above `MAX_WIDTH` is clamped to `MAX_WIDTH` (4 at default).
- R4: Each micro-op takes one reorder-buffer entry, and the dispatched micro-op total never exceeds `rob_free`.
- R5: With `cfg_preg_limit` nonzero, `preg_used` plus the destination counts of the accepted instructions never exceeds the limit. A limit of 0 makes the register supply unbounded, so it never refuses an instruction.
- R6: Each micro-op takes one scheduler entry, and the dispatched micro-op total never exceeds `sched_free`.
- R7: Each accepted instruction with its load flag set takes one load-queue slot out of `lq_free`. Each one with its store flag set takes one store-queue slot out of `sq_free`.
- R8: An instruction with its solo flag set is accepted only in lane 0, and no lane after it is accepted in that cycle.
- R9: `stall_code` is 0 when every valid lane is taken, when the first refused lane is invalid, or when that lane failed the width check. Otherwise the code names the first failing check in this priority: 1 register, 2 reorder buffer, 3 scheduler, 4 load queue, 5 store queue, 6 group rule.
- R10: Each cycle with a nonzero `stall_code` c adds one to the counter at `stall_cnt[(c-1)*CW +: CW]`.
- R11: Each cycle adds one to the histogram bin at `uop_hist[N*CW +: CW]`, where N is that cycle's `disp_uops`.
- R12: Every counter stops at 2^CW-1 and does not wrap.
- R13: Reset or a cycle with `clear_stats` high leaves every counter at 0 after the edge. Clear wins over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_stats | input | 1 | Synchronous clear of all counters |
| cfg_width | input | WW | Dispatch width in micro-ops (0 selects default) |
| cfg_preg_limit | input | FW | Physical register limit (0 = unbounded) |
| preg_used | input | FW | Physical registers currently allocated |
| rob_free | input | FW | Free reorder-buffer entries |
| sched_free | input | FW | Free scheduler queue entries |
| lq_free | input | FW | Free load-queue entries |
| sq_free | input | FW | Free store-queue entries |
| in_valid | input | LANES | Lane holds an instruction, lane 0 oldest |
| in_uops | input | LANES*UW | Micro-op count per lane, lane i at [i*UW +: UW] |
| in_dsts | input | LANES*DW | Destination register count per lane, lane i at [i*DW +: DW] |
| in_load | input | LANES | Lane instruction needs a load-queue slot |
| in_store | input | LANES | Lane instruction needs a store-queue slot |
| in_solo | input | LANES | Lane instruction must dispatch alone at group start |
| in_ready | output | LANES | Lane dispatched this cycle |
| disp_uops | output | WW | Micro-ops dispatched this cycle |
| stall_code | output | 3 | Classified stall cause (0 = none) |
| stall_cnt | output | 6*CW | Saturating stall counters, cause c at [(c-1)*CW +: CW] |
| uop_hist | output | (MAX_WIDTH+1)*CW | Per-cycle dispatch histogram, bin N at [N*CW +: CW] |

## Verification
The bench builds the block with four lanes, a maximum width of 4 and a default width of 2. Both the zero-width default and the clamp above the maximum are therefore reachable with a 3-bit width field. Counters are narrowed to 4 bits, so saturation at 15 takes only a short run of stalled or idle cycles. Six-bit free counts let single-digit values starve each resource in turn. They also let several resources run short together, which exercises the cause priority.

// File: rtl/dispatch_gate.sv
module dispatch_gate #(
  parameter int LANES     = 4,
  parameter int MAX_WIDTH = 4,
  parameter int DEF_WIDTH = 2,
  parameter int UW        = 3,
  parameter int DW        = 2,
  parameter int FW        = 6,
  parameter int CW        = 16,
  localparam int WW       = $clog2(MAX_WIDTH + 1),
  localparam int NCAUSE   = 6,
  localparam int NBIN     = MAX_WIDTH + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_stats,
  input  logic [WW-1:0]          cfg_width,
  input  logic [FW-1:0]          cfg_preg_limit,
  input  logic [FW-1:0]          preg_used,
  input  logic [FW-1:0]          rob_free,
  input  logic [FW-1:0]          sched_free,
  input  logic [FW-1:0]          lq_free,
  input  logic [FW-1:0]          sq_free,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES*UW-1:0]    in_uops,
  input  logic [LANES*DW-1:0]    in_dsts,
  input  logic [LANES-1:0]       in_load,
  input  logic [LANES-1:0]       in_store,
  input  logic [LANES-1:0]       in_solo,
  output logic [LANES-1:0]       in_ready,
  output logic [WW-1:0]          disp_uops,
  output logic [2:0]             stall_code,
  output logic [NCAUSE*CW-1:0]   stall_cnt,
  output logic [NBIN*CW-1:0]     uop_hist
);

  localparam int SUMW = FW + UW + $clog2(LANES + 1);
  localparam logic [2:0] C_NONE = 3'd0, C_REG = 3'd1, C_ROB = 3'd2,
                         C_SCH = 3'd3, C_LQ = 3'd4, C_SQ = 3'd5, C_GRP = 3'd6;
  localparam logic [CW-1:0] CMAX = '1;

  logic [WW-1:0] eff_w;
  assign eff_w = (cfg_width == '0) ? WW'(DEF_WIDTH)
               : (cfg_width > WW'(MAX_WIDTH)) ? WW'(MAX_WIDTH) : cfg_width;

  logic [SUMW-1:0] cu, cd, cl, cs, u, d;
  logic go, prev_solo, ok_w, ok_reg, ok_rob, ok_sch, ok_lq, ok_sq, ok_grp;
  logic [LANES-1:0] take;
  logic [2:0] code;

  always_comb begin
    cu = '0; cd = '0; cl = '0; cs = '0; u = '0; d = '0;
    go = 1'b1; prev_solo = 1'b0; take = '0; code = C_NONE;
    ok_w = 1'b0; ok_reg = 1'b0; ok_rob = 1'b0; ok_sch = 1'b0;
    ok_lq = 1'b0; ok_sq = 1'b0; ok_grp = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      u      = SUMW'(in_uops[i*UW +: UW]);
      d      = SUMW'(in_dsts[i*DW +: DW]);
      ok_w   = (cu + u) <= SUMW'(eff_w);
      ok_rob = (cu + u) <= SUMW'(rob_free);
      ok_sch = (cu + u) <= SUMW'(sched_free);
      ok_reg = (cfg_preg_limit == '0) ||
               ((SUMW'(preg_used) + cd + d) <= SUMW'(cfg_preg_limit));
      ok_lq  = !in_load[i]  || ((cl + SUMW'(1)) <= SUMW'(lq_free));
      ok_sq  = !in_store[i] || ((cs + SUMW'(1)) <= SUMW'(sq_free));
      ok_grp = !prev_solo && !(in_solo[i] && (i != 0));
      if (go && in_valid[i]) begin
        if (ok_w && ok_rob && ok_sch && ok_reg && ok_lq && ok_sq && ok_grp) begin
          take[i]   = 1'b1;
          cu        = cu + u;
          cd        = cd + d;
          cl        = cl + SUMW'(in_load[i]);
          cs        = cs + SUMW'(in_store[i]);
          prev_solo = in_solo[i];
        end else begin
          go = 1'b0;
          if (!ok_w)        code = C_NONE;
          else if (!ok_reg) code = C_REG;
          else if (!ok_rob) code = C_ROB;
          else if (!ok_sch) code = C_SCH;
          else if (!ok_lq)  code = C_LQ;
          else if (!ok_sq)  code = C_SQ;
          else              code = C_GRP;
        end
      end else begin
        go = 1'b0;
      end
    end
  end

  assign in_ready   = take;
  assign disp_uops  = WW'(cu);
  assign stall_code = code;

  logic [CW-1:0] stall_q [NCAUSE];
  logic [CW-1:0] hist_q  [NBIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCAUSE; k++) stall_q[k] <= '0;
      for (int n = 0; n < NBIN; n++)   hist_q[n]  <= '0;
    end else if (clear_stats) begin
      for (int k = 0; k < NCAUSE; k++) stall_q[k] <= '0;
      for (int n = 0; n < NBIN; n++)   hist_q[n]  <= '0;
    end else begin
      for (int k = 0; k < NCAUSE; k++)
        if (code == 3'(k + 1) && stall_q[k] != CMAX) stall_q[k] <= stall_q[k] + 1'b1;
      for (int n = 0; n < NBIN; n++)
        if (disp_uops == WW'(n) && hist_q[n] != CMAX) hist_q[n] <= hist_q[n] + 1'b1;
    end
  end

  for (genvar k = 0; k < NCAUSE; k++) begin : g_stall_out
    assign stall_cnt[k*CW +: CW] = stall_q[k];
    assert_stall_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_stats |=> stall_q[k] >= $past(stall_q[k]));
    assert_stall_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
      clear_stats |=> stall_q[k] == '0);
  end

  for (genvar n = 0; n < NBIN; n++) begin : g_hist_out
    assign uop_hist[n*CW +: CW] = hist_q[n];
    assert_hist_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_stats |=> hist_q[n] >= $past(hist_q[n]));
  end

  assert_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ready & ~in_valid) == '0) && ((LANES'(in_ready + 1'b1) & in_ready) == '0));
  assert_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_uops <= ((cfg_width == '0) ? WW'(DEF_WIDTH) : cfg_width));
  assert_rob_R4: assert property (@(posedge clk) disable iff (!rst_n)
    FW'(disp_uops) <= rob_free);
  assert_sched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    FW'(disp_uops) <= sched_free);
  assert_stall_refusal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_code != C_NONE) |-> (in_ready != in_valid) && (stall_code <= C_GRP));

endmodule

// File: tb/test_dispatch_gate.sv
module test_dispatch_gate;
  localparam int CW = 4;
  localparam int LANES = 4;

  typedef struct packed {
    logic [2:0]  w;
    logic [5:0]  plim, pused, rob, sch, lq, sq;
    logic [3:0]  v;
    logic [11:0] u;
    logic [7:0]  d;
    logic [3:0]  ld, st, so;
    logic [3:0]  er;
    logic [3:0]  eu;
    logic [2:0]  ec;
  } vec_t;

  localparam logic [11:0] U1 = {3'd1, 3'd1, 3'd1, 3'd1};
  localparam logic [7:0]  D1 = {2'd1, 2'd1, 2'd1, 2'd1};
  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h0, 4'hF, 4'd4, 3'd0}, // R2 fits exactly
    '{3'd0, 6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h0, 4'h3, 4'd2, 3'd0}, // R3 default width
    '{3'd7, 6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 4'hF, {3'd1,3'd1,3'd1,3'd2}, D1, 4'h0, 4'h0, 4'h0, 4'h7, 4'd4, 3'd0}, // R3 clamp
    '{3'd4, 6'd0,  6'd0,  6'd2,  6'd63, 6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h0, 4'h3, 4'd2, 3'd2}, // R4
    '{3'd4, 6'd10, 6'd8,  6'd63, 6'd63, 6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h0, 4'h3, 4'd2, 3'd1}, // R5 limit
    '{3'd4, 6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 4'hF, U1, 8'hFF, 4'h0, 4'h0, 4'h0, 4'hF, 4'd4, 3'd0}, // R5 unbounded
    '{3'd4, 6'd5,  6'd5,  6'd1,  6'd0,  6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h0, 4'h0, 4'd0, 3'd1}, // R9 reg first
    '{3'd4, 6'd0,  6'd0,  6'd0,  6'd0,  6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h0, 4'h0, 4'd0, 3'd2}, // R9 rob over sched
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd3,  6'd63, 6'd63, 4'hF, {3'd1,3'd1,3'd2,3'd2}, D1, 4'h0, 4'h0, 4'h0, 4'h1, 4'd2, 3'd3}, // R6
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd63, 6'd2,  6'd63, 4'hF, U1, D1, 4'hF, 4'h0, 4'h0, 4'h3, 4'd2, 3'd4}, // R7 loads
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd1,  4'hF, U1, D1, 4'h0, 4'h5, 4'h0, 4'h3, 4'd2, 3'd5}, // R7 stores
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd63, 6'd0,  6'd0,  4'hF, U1, D1, 4'h1, 4'h1, 4'h0, 4'h0, 4'd0, 3'd4}, // R9 lq over sq
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h4, 4'h3, 4'd2, 3'd6}, // R8 solo late
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h1, 4'h1, 4'd1, 3'd6}, // R8 solo leads
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 4'h5, U1, D1, 4'h0, 4'h0, 4'h0, 4'h1, 4'd1, 3'd0}, // R1 hole
    '{3'd4, 6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 4'h0, U1, D1, 4'h0, 4'h0, 4'h0, 4'h0, 4'd0, 3'd0}, // R1 empty
    '{3'd2, 6'd0,  6'd0,  6'd2,  6'd63, 6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h0, 4'h3, 4'd2, 3'd0}, // R9 width not a stall
    '{3'd4, 6'd1,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 4'hF, U1, D1, 4'h0, 4'h0, 4'h2, 4'h1, 4'd1, 3'd1}  // R9 reg over group
  };

  logic clk = 1'b0, rst_n = 1'b0, clear_stats = 1'b0;
  logic [2:0] cfg_width;
  logic [5:0] cfg_preg_limit, preg_used, rob_free, sched_free, lq_free, sq_free;
  logic [3:0] in_valid, in_load, in_store, in_solo, in_ready;
  logic [11:0] in_uops;
  logic [7:0] in_dsts;
  logic [2:0] disp_uops, stall_code;
  logic [6*CW-1:0] stall_cnt;
  logic [5*CW-1:0] uop_hist;

  always #5 clk = ~clk;

  dispatch_gate #(.LANES(LANES), .MAX_WIDTH(4), .DEF_WIDTH(2), .UW(3), .DW(2), .FW(6), .CW(CW)) i_dispatch_gate (
    .clk(clk), .rst_n(rst_n), .clear_stats(clear_stats), .cfg_width(cfg_width),
    .cfg_preg_limit(cfg_preg_limit), .preg_used(preg_used), .rob_free(rob_free),
    .sched_free(sched_free), .lq_free(lq_free), .sq_free(sq_free), .in_valid(in_valid),
    .in_uops(in_uops), .in_dsts(in_dsts), .in_load(in_load), .in_store(in_store),
    .in_solo(in_solo), .in_ready(in_ready), .disp_uops(disp_uops), .stall_code(stall_code),
    .stall_cnt(stall_cnt), .uop_hist(uop_hist));

  int checks = 0, fails = 0;
  bit done = 0;
  int st_exp [6];
  int hist_exp [5];

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic apply(input vec_t t);
    cfg_width = t.w; cfg_preg_limit = t.plim; preg_used = t.pused;
    rob_free = t.rob; sched_free = t.sch; lq_free = t.lq; sq_free = t.sq;
    in_valid = t.v; in_uops = t.u; in_dsts = t.d;
    in_load = t.ld; in_store = t.st; in_solo = t.so;
  endtask

  function automatic int satv(input int x);
    return (x > 15) ? 15 : x;
  endfunction

  initial begin
    apply(TBL[15]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < 6; k++) check("R13 reset stall counter", int'(stall_cnt[k*CW +: CW]), 0);
    check("R13 reset hist bin0", int'(uop_hist[0 +: CW]), 0);
    check("R9 idle code", int'(stall_code), 0);

    @(negedge clk) clear_stats = 1'b1;
    @(negedge clk) clear_stats = 1'b0;
    for (int k = 0; k < 6; k++) st_exp[k] = 0;
    for (int n = 0; n < 5; n++) hist_exp[n] = 0;
    for (int i = 0; i < NV; i++) begin
      if (i != 0) @(negedge clk);
      apply(TBL[i]);
      #1;
      check($sformatf("R1 R2 vector %0d in_ready", i), int'(in_ready), int'(TBL[i].er));
      check($sformatf("R2 vector %0d disp_uops", i), int'(disp_uops), int'(TBL[i].eu));
      check($sformatf("R9 vector %0d stall_code", i), int'(stall_code), int'(TBL[i].ec));
      if (TBL[i].ec != 0) st_exp[TBL[i].ec - 1]++;
      hist_exp[TBL[i].eu]++;
    end
    @(negedge clk) apply(TBL[15]);
    #1;
    for (int k = 0; k < 6; k++)
      check($sformatf("R10 stall counter %0d", k + 1), int'(stall_cnt[k*CW +: CW]), satv(st_exp[k]));
    for (int n = 0; n < 5; n++)
      check($sformatf("R11 hist bin %0d", n), int'(uop_hist[n*CW +: CW]), satv(hist_exp[n]));

    // R12: saturation of a stall counter and of histogram bin 0
    @(negedge clk) apply(TBL[6]);
    repeat (20) @(negedge clk);
    #1;
    check("R12 reg stall counter saturates", int'(stall_cnt[0 +: CW]), 15);
    check("R12 hist bin0 saturates", int'(uop_hist[0 +: CW]), 15);

    // R13: clear wins over a stalling cycle
    @(negedge clk) clear_stats = 1'b1;
    @(negedge clk) begin clear_stats = 1'b0; apply(TBL[15]); end
    #1;
    check("R13 clear beats count, reg counter", int'(stall_cnt[0 +: CW]), 0);
    check("R13 clear beats count, hist bin0", int'(uop_hist[0 +: CW]), 0);
    @(negedge clk);
    #1;
    check("R11 counting resumes after clear", int'(uop_hist[0 +: CW]), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule